// File: doc/BRIEF.md
# Table Base Register Bank

This block holds the base-address registers for the in-memory tables of an interrupt translation unit. It has eight 64-bit slots in the register map. Slot 0 describes the device table and slot 1 the collection table. Slots 2 to 7 are reserved: they read as zero and drop every write. Software reaches the slots over a simple register bus. Each access is either a full 64-bit transfer or a 32-bit transfer to one half of a slot.

Every accepted write first merges the new data into the current slot value, then passes the result through a sanitiser, and only then stores it. The sanitiser pins the fields this implementation does not support to fixed values, so a readback always shows what the hardware will actually use. While the unit's global enable input is high, the table layout is frozen and every write to the bank is dropped. Reads return one cycle later on a registered data port.

Slot layout (bit positions are behaviour, since table walkers decode them):
- [7:0] table size (kept)
- [9:8] page size
- [11:10] shareability
- [15:12] high physical address bits
- [47:16] base address (kept)
- [52:48] entry size minus one
- [55:53] outer cacheability
- [58:56] table type
- [61:59] inner cacheability
- [62] two-level (indirect) table flag
- [63] valid (kept)

Top module: `tbr_bank`

## Requirements
- R1: After synchronous reset, slot 0 reads 0x1907_0000_0000_0600 and slot 1 reads 0x1C07_0000_0000_0600. In both values: inner cacheability is 3 (read-allocate write-back), outer is 0 (same as inner), shareability is 1 (inner shareable), entry size is 7, page size code is 2 (64 KB), and the type is 1 for slot 0 and 4 for slot 1.
- R2: A read request (bus_valid=1, bus_write=0) sampled at clock edge k produces rd_valid=1 and rd_data after edge k, both held for one cycle. At every other time rd_valid is 0.
- R3: The slot index is bus_addr[5:3]. Indices 2 to 7 always read zero, and writes to them change no slot.
- R4: While glob_en is 1 at the write's clock edge, the write changes neither slot 0 nor slot 1.
- R5: On every write, the type field [58:56] is forced to 1 (slot 0) or 4 (slot 1), the entry size field [52:48] is forced to 7, and the page size field [9:8] is forced to 2. The written values of bits [58:56] and [52:48] are discarded.
- R6: Bits [15:12] always read back as zero after a write.
- R7: Bit 62 is kept as written in slot 0 and always reads zero in slot 1.
- R8: A shareability code of 3 (reserved) is stored as 1. Codes 0, 1 and 2 are stored unchanged.
- R9: Inner cacheability codes 0, 2, 4 and 6 (device and write-through types) are stored as 3, and odd codes are kept. Outer cacheability codes 2, 4 and 6 are stored as 0, and codes 0, 1, 3, 5 and 7 are kept.
- R10: With bus_wide=0, bus_addr[2] picks the half: 0 for bits [31:0], 1 for bits [63:32]. A write merges bus_wdata[31:0] into that half, keeps the other half, and sanitises the whole result. A read returns that half zero-extended in rd_data[31:0]. With bus_wide=1, bus_addr[2] is ignored and all 64 bits are transferred.
- R11: Bits [7:0], [47:16] and [63] are stored exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glob_en | input | 1 | Unit enable; while high, writes to the bank are dropped |
| bus_valid | input | 1 | Access request strobe |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_wide | input | 1 | 1 for a 64-bit access, 0 for a 32-bit access |
| bus_addr | input | 6 | Byte offset into the bank |
| bus_wdata | input | 64 | Write data (only [31:0] is used for 32-bit writes) |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 64 | Registered read data |

## Verification
A write takes effect at the clock edge that samples it, so a read issued in any later cycle already sees the new value. Read data and rd_valid appear one edge after the request. The driver issues each access just after a rising edge and pushes the value the request should return into a queue. The monitor compares results at the falling edge that follows the capture edge, one entry per rd_valid pulse, so every comparison lands in the single cycle where the result is defined. Sanitising is checked only through readback, so each write is followed by reads of the whole slot and of both halves.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

  localparam int REG_W = 64;
  localparam int HALF_W = REG_W / 2;

  // field positions (decoded by table walkers)
  localparam int F_SIZE_LO  = 0;
  localparam int F_SIZE_HI  = 7;
  localparam int F_PAGE_LO  = 8;
  localparam int F_PAGE_HI  = 9;
  localparam int F_SHR_LO   = 10;
  localparam int F_SHR_HI   = 11;
  localparam int F_HPA_LO   = 12;
  localparam int F_HPA_HI   = 15;
  localparam int F_ESZ_LO   = 48;
  localparam int F_ESZ_HI   = 52;
  localparam int F_OCA_LO   = 53;
  localparam int F_OCA_HI   = 55;
  localparam int F_TYP_LO   = 56;
  localparam int F_TYP_HI   = 58;
  localparam int F_ICA_LO   = 59;
  localparam int F_ICA_HI   = 61;
  localparam int F_IND      = 62;

  localparam logic [1:0] PAGE_64K     = 2'd2;
  localparam logic [1:0] SHR_INNER    = 2'd1;
  localparam logic [1:0] SHR_RSVD     = 2'd3;
  localparam logic [2:0] ICA_RAWB     = 3'd3;
  localparam logic [2:0] OCA_SAME     = 3'd0;
  localparam logic [4:0] ESZ_8BYTE    = 5'd7;

  typedef enum logic [2:0] {
    TBL_NONE   = 3'd0,
    TBL_DEVICE = 3'd1,
    TBL_COLL   = 3'd4
  } tbl_type_e;

  function automatic logic [REG_W-1:0] slot_reset(input tbl_type_e ty);
    logic [REG_W-1:0] v;
    v = '0;
    v[F_ICA_HI:F_ICA_LO]   = ICA_RAWB;
    v[F_OCA_HI:F_OCA_LO]   = OCA_SAME;
    v[F_SHR_HI:F_SHR_LO]   = SHR_INNER;
    v[F_ESZ_HI:F_ESZ_LO]   = ESZ_8BYTE;
    v[F_PAGE_HI:F_PAGE_LO] = PAGE_64K;
    v[F_TYP_HI:F_TYP_LO]   = ty;
    return v;
  endfunction

endpackage

// File: rtl/tbr_sanitise.sv
module tbr_sanitise
  import tbr_pkg::*;
#(
  parameter tbl_type_e TYPE_CODE   = TBL_DEVICE,
  parameter bit        DROP_INDIR  = 1'b0
) (
  input  logic [REG_W-1:0] cur_val,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wide,
  input  logic             upper,
  output logic [REG_W-1:0] clean_val
);

  logic [REG_W-1:0] merged;
  logic [1:0]       shr_in;
  logic [2:0]       ica_in;
  logic [2:0]       oca_in;

  always_comb begin
    merged = cur_val;
    if (wide) begin
      merged = wr_data;
    end else if (upper) begin
      merged[REG_W-1:HALF_W] = wr_data[HALF_W-1:0];
    end else begin
      merged[HALF_W-1:0] = wr_data[HALF_W-1:0];
    end
  end

  assign shr_in = merged[F_SHR_HI:F_SHR_LO];
  assign ica_in = merged[F_ICA_HI:F_ICA_LO];
  assign oca_in = merged[F_OCA_HI:F_OCA_LO];

  always_comb begin
    clean_val = merged;
    // read-only ranges cleared before forced fields are inserted
    clean_val[F_ESZ_HI:F_ESZ_LO] = '0;
    clean_val[F_TYP_HI:F_TYP_LO] = '0;
    clean_val[F_HPA_HI:F_HPA_LO] = '0;
    if (DROP_INDIR) clean_val[F_IND] = 1'b0;

    clean_val[F_ESZ_HI:F_ESZ_LO]   = ESZ_8BYTE;
    clean_val[F_TYP_HI:F_TYP_LO]   = TYPE_CODE;
    clean_val[F_PAGE_HI:F_PAGE_LO] = PAGE_64K;

    if (shr_in == SHR_RSVD) clean_val[F_SHR_HI:F_SHR_LO] = SHR_INNER;

    // device and write-through inner attributes are not supported
    if (!ica_in[0]) clean_val[F_ICA_HI:F_ICA_LO] = ICA_RAWB;

    case (oca_in)
      3'd2, 3'd4, 3'd6: clean_val[F_OCA_HI:F_OCA_LO] = OCA_SAME;
      default:          clean_val[F_OCA_HI:F_OCA_LO] = oca_in;
    endcase
  end

endmodule

// File: rtl/tbr_slot.sv
module tbr_slot
  import tbr_pkg::*;
#(
  parameter tbl_type_e TYPE_CODE  = TBL_DEVICE,
  parameter bit        DROP_INDIR = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wide,
  input  logic             upper,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] value
);

  logic [REG_W-1:0] value_q;
  logic [REG_W-1:0] next_val;

  tbr_sanitise #(
    .TYPE_CODE  (TYPE_CODE),
    .DROP_INDIR (DROP_INDIR)
  ) u_san (
    .cur_val   (value_q),
    .wr_data   (wr_data),
    .wide      (wide),
    .upper     (upper),
    .clean_val (next_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q <= slot_reset(TYPE_CODE);
    end else if (wr_en) begin
      value_q <= next_val;
    end
  end

  assign value = value_q;

endmodule

// File: rtl/tbr_read_mux.sv
module tbr_read_mux
  import tbr_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0][REG_W-1:0] slot_vals,
  input  logic [IDX_W-1:0]                idx,
  input  logic                            wide,
  input  logic                            upper,
  output logic [REG_W-1:0]                data
);

  logic [REG_W-1:0] sel;

  assign sel = slot_vals[idx];

  always_comb begin
    if (wide) begin
      data = sel;
    end else if (upper) begin
      data = {{HALF_W{1'b0}}, sel[REG_W-1:HALF_W]};
    end else begin
      data = {{HALF_W{1'b0}}, sel[HALF_W-1:0]};
    end
  end

endmodule

// File: rtl/tbr_bank.sv
module tbr_bank
  import tbr_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int ADDR_W   = IDX_W + 3,
  localparam int NUM_IMPL = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              glob_en,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_wide,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic              rd_valid,
  output logic [REG_W-1:0]  rd_data
);

  logic [IDX_W-1:0]                slot_idx;
  logic                            half_sel;
  logic                            wr_ok;
  logic [NUM_SLOTS-1:0][REG_W-1:0] slot_vals;
  logic [REG_W-1:0]                rd_next;
  logic                            rd_valid_q;
  logic [REG_W-1:0]                rd_data_q;

  assign slot_idx = bus_addr[ADDR_W-1:3];
  assign half_sel = bus_addr[2];
  assign wr_ok    = bus_valid & bus_write & ~glob_en;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    if (i < NUM_IMPL) begin : g_impl
      localparam tbl_type_e TY = (i == 0) ? TBL_DEVICE : TBL_COLL;
      tbr_slot #(
        .TYPE_CODE  (TY),
        .DROP_INDIR (i != 0)
      ) u_slot (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ok && (slot_idx == IDX_W'(i))),
        .wide    (bus_wide),
        .upper   (half_sel),
        .wr_data (bus_wdata),
        .value   (slot_vals[i])
      );
    end else begin : g_rsvd
      assign slot_vals[i] = '0;
    end
  end

  tbr_read_mux #(
    .NUM_SLOTS (NUM_SLOTS)
  ) u_rmux (
    .slot_vals (slot_vals),
    .idx       (slot_idx),
    .wide      (bus_wide),
    .upper     (half_sel),
    .data      (rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= bus_valid & ~bus_write;
      if (bus_valid && !bus_write) rd_data_q <= rd_next;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

endmodule

// File: rtl/tbr_bank_chk.sv
module tbr_bank_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              glob_en,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rd_valid,
  input logic [63:0]       rd_data,
  input logic [63:0]       dev_q,
  input logic [63:0]       col_q
);

  // R2
  rd_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> rd_valid);

  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> !rd_valid);

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && (bus_addr[ADDR_W-1:3] > 1)) |=> (rd_data == 64'd0));

  // R4
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    glob_en |=> ($stable(dev_q) && $stable(col_q)));

  // R5
  forced_dev_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_q[58:56] == 3'd1) && (dev_q[52:48] == 5'd7) && (dev_q[9:8] == 2'd2));

  // R5
  forced_col_chk: assert property (@(posedge clk) disable iff (rst)
    (col_q[58:56] == 3'd4) && (col_q[52:48] == 5'd7) && (col_q[9:8] == 2'd2));

  // R6
  hi_pa_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_q[15:12] == 4'd0) && (col_q[15:12] == 4'd0));

  // R7
  col_indir_chk: assert property (@(posedge clk) disable iff (rst)
    !col_q[62]);

  // R8
  shr_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_q[11:10] != 2'd3) && (col_q[11:10] != 2'd3));

endmodule

bind tbr_bank tbr_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .glob_en   (glob_en),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .dev_q     (slot_vals[0]),
  .col_q     (slot_vals[1])
);

// File: tb/tbr_bank_tb.sv
module tbr_bank_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        glob_en = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic        bus_wide = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic        rd_valid;
  logic [63:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] mdl [2];

  always #2.5 clk = ~clk;

  tbr_bank u_dut (
    .clk       (clk),
    .rst       (rst),
    .glob_en   (glob_en),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_wide  (bus_wide),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  function automatic logic [63:0] model_clean(input logic [63:0] v, input bit coll);
    logic [63:0] keep;
    logic [63:0] r;
    logic [1:0]  sh;
    logic [2:0]  ic;
    logic [2:0]  oc;
    keep = 64'h8000_FFFF_FFFF_00FF;
    if (!coll) keep[62] = 1'b1;
    r  = v & keep;
    sh = (v[11:10] == 2'd3) ? 2'd1 : v[11:10];
    ic = v[59] ? v[61:59] : 3'd3;
    oc = (v[55:53] inside {3'd2, 3'd4, 3'd6}) ? 3'd0 : v[55:53];
    r = r | (64'(ic) << 59) | (64'(oc) << 53) | (64'(sh) << 10)
          | (64'd7 << 48) | (64'(coll ? 3'd4 : 3'd1) << 56) | (64'd2 << 8);
    return r;
  endfunction

  task automatic drive(input bit wr, input int slot, input bit wide, input bit hi,
                       input logic [63:0] d);
    @(posedge clk);
    #1;
    bus_valid = 1'b1;
    bus_write = wr;
    bus_wide  = wide;
    bus_addr  = {slot[2:0], hi, 2'b00};
    bus_wdata = d;
  endtask

  task automatic idle();
    @(posedge clk);
    #1;
    bus_valid = 1'b0;
    bus_write = 1'b0;
  endtask

  task automatic wr_reg(input int slot, input bit wide, input bit hi, input logic [63:0] d);
    logic [63:0] m;
    drive(1'b1, slot, wide, hi, d);
    if (!glob_en && slot < 2) begin
      m = mdl[slot];
      if (wide) m = d;
      else if (hi) m = {d[31:0], m[31:0]};
      else m = {m[63:32], d[31:0]};
      mdl[slot] = model_clean(m, slot == 1);
    end
  endtask

  task automatic rd_reg(input int slot, input bit wide, input bit hi, input string tag);
    logic [63:0] e;
    e = (slot < 2) ? mdl[slot] : 64'd0;
    if (!wide) e = hi ? {32'd0, e[63:32]} : {32'd0, e[31:0]};
    exp_q.push_back(e);
    tag_q.push_back(tag);
    drive(1'b0, slot, wide, hi, 64'd0);
  endtask

  task automatic rd_all(input int slot, input string tag);
    rd_reg(slot, 1'b1, 1'b0, tag);
    rd_reg(slot, 1'b0, 1'b0, tag);
    rd_reg(slot, 1'b0, 1'b1, tag);
  endtask

  // monitor: one expected item per read result
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R2 unexpected rd_valid actual=%h expected=none", rd_data);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mdl[0] = 64'h1907_0000_0000_0600;
    mdl[1] = 64'h1C07_0000_0000_0600;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0 || rd_data !== 64'd0) begin
      failures++;
      $display("FAIL R2 reset outputs actual=%b/%h expected=0/0", rd_valid, rd_data);
    end

    // R1 reset values, R3 reserved slot
    rd_all(0, "R1 dev reset");
    rd_all(1, "R1 coll reset");
    rd_reg(5, 1'b1, 1'b0, "R3 reserved reset");

    // R5 R6 R7 all-ones writes
    wr_reg(0, 1'b1, 1'b0, '1);
    rd_all(0, "R5 R6 R7 dev ones");
    wr_reg(1, 1'b1, 1'b0, '1);
    rd_all(1, "R5 R6 R7 coll ones");

    // R3 writes to reserved slots are dropped
    wr_reg(3, 1'b1, 1'b0, 64'hDEAD_BEEF_CAFE_F00D);
    wr_reg(7, 1'b0, 1'b1, 64'h1234_5678);
    rd_reg(3, 1'b1, 1'b0, "R3 reserved write");
    rd_reg(7, 1'b0, 1'b1, "R3 reserved write half");
    rd_all(0, "R3 dev untouched");
    rd_all(1, "R3 coll untouched");

    // R11 preserved fields, R8 shareability 2 kept
    wr_reg(0, 1'b1, 1'b0, 64'h8000_1234_5678_08AB);
    rd_all(0, "R11 R8 dev preserved");
    wr_reg(1, 1'b1, 1'b0, 64'h4000_ABCD_0000_F03C);
    rd_all(1, "R11 R7 coll");

    // R4 enable freezes the bank
    idle();
    glob_en = 1'b1;
    wr_reg(0, 1'b1, 1'b0, 64'h0);
    wr_reg(1, 1'b0, 1'b0, 64'h0);
    rd_all(0, "R4 dev frozen");
    rd_all(1, "R4 coll frozen");
    idle();
    glob_en = 1'b0;

    // R10 half writes merge
    wr_reg(0, 1'b0, 1'b1, 64'h0000_0000_C012_3456);
    rd_all(0, "R10 upper half");
    wr_reg(0, 1'b0, 1'b0, 64'h0000_0000_7654_FC21);
    rd_all(0, "R10 lower half");
    wr_reg(1, 1'b0, 1'b1, 64'hFFFF_FFFF_0000_0000);
    rd_all(1, "R10 data upper ignored");

    // R8 each shareability code
    for (int s = 0; s < 4; s++) begin
      wr_reg(0, 1'b1, 1'b0, 64'h0000_0001_0000_0000 | (64'(s) << 10));
      rd_reg(0, 1'b1, 1'b0, "R8 shareability");
    end

    // R9 each inner and outer cacheability code
    for (int c = 0; c < 8; c++) begin
      wr_reg(1, 1'b1, 1'b0, (64'(c) << 59) | (64'(7 - c) << 53));
      rd_reg(1, 1'b1, 1'b0, "R9 cacheability");
      wr_reg(0, 1'b1, 1'b0, (64'(c) << 53) | (64'(c) << 59));
      rd_reg(0, 1'b1, 1'b0, "R9 cacheability dev");
    end

    // R5 written type and entry size bits discarded
    wr_reg(0, 1'b1, 1'b0, 64'h0610_0000_0000_0300);
    rd_reg(0, 1'b1, 1'b0, "R5 forced fields");

    idle();
    repeat (4) @(posedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R2 missing results actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule